// File: doc/BRIEF.md
# Error-Tagged UART Receiver

This block turns an asynchronous serial line into a queue of received characters. A 16x oversampling tick paces the sampling. The character format is set by a word-length code, a parity enable and a parity-kind select. Each completed frame goes into a 64-entry FIFO. Every entry carries three error tags beside the character: break, framing and parity.

The status outputs always describe the entry at the head of the FIFO, which is the next character to be popped, and not the most recent frame received. Software can therefore read the status first and then pop the data, and the tags it sees belong to that character. A summary flag stays high while any stored entry carries a tag. An overrun flag records frames that were lost because the FIFO was full. Reading the status clears it.

Top module: `urx_top`

## Requirements
- R1: After reset every status output and `rd_data` are 0. `st_ready` is 1 exactly when the FIFO holds at least one character, and a completed frame makes it 1 on the following clock.
- R2: Data bits are taken least significant first. `cfg_wlen` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, and the character appears right-aligned in `rd_data` with the unused upper bits 0. Characters leave the FIFO in arrival order.
- R3: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_sel` selects the parity kind: 0 is odd, 1 is even, 2 is a bit that must be 1, and 3 is a bit that must be 0. A parity bit that does not match stores the parity tag with the character. When `cfg_par_en` is 0 the parity tag is never set.
- R4: A stop bit sampled low stores the framing tag with the character.
- R5: A frame in which the line is low at every sample point, start through stop, is stored as character 0x00 with both the break and framing tags set. The receiver then waits for the line to go high before it looks for a new start bit, so a long low period gives exactly one entry.
- R6: `st_brk`, `st_frm` and `st_par` are the tags of the head entry, and they change as entries are popped. They are 0 while the FIFO is empty.
- R7: `st_fifo_err` is 1 while at least one stored entry has any tag set, and it returns to 0 only when no such entry remains. This also holds when a push and a pop happen in the same cycle.
- R8: The FIFO holds 64 entries. A frame that completes while the FIFO is full, with no pop in that cycle, is discarded and sets `st_overrun`. A frame that completes while the FIFO is full and a pop happens in the same cycle is stored. `st_rd` clears `st_overrun` unless a new overrun occurs in the same cycle.
- R9: A falling edge is taken as a start bit only if the line is still low at the middle of the start bit, on the 8th tick after detection. Otherwise it is treated as a glitch and no character is produced.
- R10: A pop request while the FIFO is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| cfg_wlen | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_sel | input | 2 | Parity kind: 0 odd, 1 even, 2 forced 1, 3 forced 0 |
| rd_pop | input | 1 | Remove the head entry |
| st_rd | input | 1 | Status-read strobe; clears the overrun flag |
| rd_data | output | 8 | Head character (0 when empty) |
| st_ready | output | 1 | FIFO not empty |
| st_overrun | output | 1 | Sticky lost-frame flag |
| st_brk | output | 1 | Head entry break tag |
| st_frm | output | 1 | Head entry framing tag |
| st_par | output | 1 | Head entry parity tag |
| st_fifo_err | output | 1 | Some stored entry carries a tag |

## Verification
The hardest cases to reach from the ports need a pop in the exact cycle a frame is written: the tag summary under simultaneous increment and decrement, and the write into a full FIFO that is also being popped. The bench's behavioural model predicts the write cycle one clock ahead, and a registered auto-pop uses that prediction to raise `rd_pop` in precisely that cycle. This is done with tagged and untagged entries in both positions, and once more with all 64 entries filled.

// File: rtl/urx_pkg.sv
package urx_pkg;

    localparam int unsigned CHAR_W = 8;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_MARK  = 2'd2,
        PAR_SPACE = 2'd3
    } par_kind_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    // number of data bits for a word-length code
    function automatic logic [3:0] bits_of(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    // bits are shifted in from the top; move the character down to bit 0
    function automatic logic [CHAR_W-1:0] align_char(input logic [CHAR_W-1:0] sh,
                                                     input logic [1:0] code);
        return sh >> (2'd3 - code);
    endfunction

    function automatic logic parity_bad(input logic [CHAR_W-1:0] d,
                                        input logic pbit,
                                        input par_kind_e kind);
        logic bad;
        unique case (kind)
            PAR_ODD:  bad = ~(^d ^ pbit);
            PAR_EVEN: bad = ^d ^ pbit;
            PAR_MARK: bad = ~pbit;
            default:  bad = pbit;
        endcase
        return bad;
    endfunction

    function automatic logic has_tag(input rx_entry_t e);
        return e.brk | e.frm | e.par;
    endfunction

endpackage

// File: rtl/urx_deframer.sv
module urx_deframer
    import urx_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic [1:0] par_sel,
    output logic       vld,
    output rx_entry_t  ent
);

    localparam int unsigned CNT_W = $clog2(OVS);
    localparam int unsigned MID   = OVS / 2 - 1;
    localparam int unsigned LAST  = OVS - 1;

    rx_state_e         st;
    logic [CNT_W-1:0]  cnt;
    logic [2:0]        idx;
    logic [CHAR_W-1:0] sh;
    logic              pbit;
    logic              allz;

    logic              at_end;
    logic              last_bit;
    logic              brk_now;
    logic [CHAR_W-1:0] d_al;
    rx_entry_t         built;

    assign at_end   = (cnt == CNT_W'(LAST));
    assign last_bit = ({1'b0, idx} == bits_of(wlen) - 4'd1);

    always_comb begin
        brk_now    = allz & ~rx;
        d_al       = align_char(sh, wlen);
        built.brk  = brk_now;
        built.frm  = ~rx;
        built.par  = ~brk_now & par_en & parity_bad(d_al, pbit, par_kind_e'(par_sel));
        built.data = brk_now ? '0 : d_al;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= RX_IDLE;
            cnt  <= '0;
            idx  <= '0;
            sh   <= '0;
            pbit <= 1'b0;
            allz <= 1'b0;
            vld  <= 1'b0;
            ent  <= '0;
        end else begin
            vld <= 1'b0;
            if (tick) begin
                case (st)
                    RX_IDLE: begin
                        if (!rx) begin
                            st  <= RX_START;
                            cnt <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == CNT_W'(MID)) begin
                            cnt <= '0;
                            if (rx) begin
                                st <= RX_IDLE;
                            end else begin
                                st   <= RX_DATA;
                                idx  <= '0;
                                allz <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    RX_DATA: begin
                        if (at_end) begin
                            cnt  <= '0;
                            sh   <= {rx, sh[CHAR_W-1:1]};
                            allz <= allz & ~rx;
                            if (last_bit) begin
                                st <= par_en ? RX_PAR : RX_STOP;
                            end else begin
                                idx <= idx + 3'd1;
                            end
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    RX_PAR: begin
                        if (at_end) begin
                            cnt  <= '0;
                            pbit <= rx;
                            allz <= allz & ~rx;
                            st   <= RX_STOP;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    RX_STOP: begin
                        if (at_end) begin
                            cnt <= '0;
                            vld <= 1'b1;
                            ent <= built;
                            st  <= brk_now ? RX_HOLD : RX_IDLE;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    RX_HOLD: begin
                        if (rx) st <= RX_IDLE;
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/urx_tagfifo.sv
module urx_tagfifo
    import urx_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  rx_entry_t wr_ent,
    input  logic      pop,
    output rx_entry_t head,
    output logic      empty,
    output logic      push_ok,
    output logic      pop_ok
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned LW = $clog2(DEPTH + 1);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wp;
    logic [AW-1:0]   rp;
    logic [LW-1:0]   lvl;
    logic            full;

    assign empty   = (lvl == '0);
    assign full    = (lvl == LW'(DEPTH));
    assign pop_ok  = pop & ~empty;
    assign push_ok = push & (~full | pop_ok);
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wr_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            lvl <= '0;
        end else begin
            if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            lvl <= lvl + LW'(push_ok) - LW'(pop_ok);
        end
    end

endmodule

// File: rtl/urx_tag_tally.sv
module urx_tag_tally #(
    parameter int unsigned DEPTH = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic any
);

    localparam int unsigned LW = $clog2(DEPTH + 1);

    logic [LW-1:0] cnt;

    assign any = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   cnt <= cnt + LW'(1);
                2'b01:   cnt <= cnt - LW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/urx_top.sv
module urx_top
    import urx_pkg::*;
#(
    parameter int unsigned OVS   = 16,
    parameter int unsigned DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       rx_in,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic [1:0] cfg_par_sel,
    input  logic       rd_pop,
    input  logic       st_rd,
    output logic [7:0] rd_data,
    output logic       st_ready,
    output logic       st_overrun,
    output logic       st_brk,
    output logic       st_frm,
    output logic       st_par,
    output logic       st_fifo_err
);

    logic      chr_vld;
    rx_entry_t chr_ent;
    rx_entry_t head;
    logic      empty;
    logic      push_ok;
    logic      pop_ok;
    logic      drop;
    logic      ovr_q;

    urx_deframer #(.OVS(OVS)) i_deframer (
        .clk     (clk),
        .rst     (rst),
        .tick    (baud_tick),
        .rx      (rx_in),
        .wlen    (cfg_wlen),
        .par_en  (cfg_par_en),
        .par_sel (cfg_par_sel),
        .vld     (chr_vld),
        .ent     (chr_ent)
    );

    urx_tagfifo #(.DEPTH(DEPTH)) i_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (chr_vld),
        .wr_ent  (chr_ent),
        .pop     (rd_pop),
        .head    (head),
        .empty   (empty),
        .push_ok (push_ok),
        .pop_ok  (pop_ok)
    );

    urx_tag_tally #(.DEPTH(DEPTH)) i_tally (
        .clk (clk),
        .rst (rst),
        .inc (push_ok & has_tag(chr_ent)),
        .dec (pop_ok & has_tag(head)),
        .any (st_fifo_err)
    );

    assign drop = chr_vld & ~push_ok;

    always_ff @(posedge clk) begin
        if (rst) ovr_q <= 1'b0;
        else     ovr_q <= (ovr_q & ~st_rd) | drop;
    end

    assign st_ready   = ~empty;
    assign st_overrun = ovr_q;
    assign rd_data    = empty ? '0 : head.data;
    assign st_brk     = ~empty & head.brk;
    assign st_frm     = ~empty & head.frm;
    assign st_par     = ~empty & head.par;

endmodule

// File: rtl/urx_checker.sv
module urx_checker (
    input logic       clk,
    input logic       rst,
    input logic       chr_vld,
    input logic       drop,
    input logic       rd_pop,
    input logic       st_rd,
    input logic [7:0] rd_data,
    input logic       st_ready,
    input logic       st_overrun,
    input logic       st_brk,
    input logic       st_frm,
    input logic       st_par,
    input logic       st_fifo_err
);

    a_r1_char_makes_ready: assert property (@(posedge clk) disable iff (rst)
        chr_vld |=> st_ready);

    a_r6_no_tags_when_empty: assert property (@(posedge clk) disable iff (rst)
        !st_ready |-> !(st_brk || st_frm || st_par));

    a_r7_err_needs_data: assert property (@(posedge clk) disable iff (rst)
        st_fifo_err |-> st_ready);

    a_r7_head_tag_in_summary: assert property (@(posedge clk) disable iff (rst)
        (st_brk || st_frm || st_par) |-> st_fifo_err);

    a_r5_break_is_null: assert property (@(posedge clk) disable iff (rst)
        st_brk |-> (rd_data == 8'h00 && st_frm));

    a_r8_drop_sets_overrun: assert property (@(posedge clk) disable iff (rst)
        drop |=> st_overrun);

    a_r8_read_clears_overrun: assert property (@(posedge clk) disable iff (rst)
        (st_rd && !drop) |=> !st_overrun);

    a_r10_empty_pop_no_effect: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && !st_ready && !chr_vld) |=> !st_ready);

endmodule

bind urx_top urx_checker i_chk (
    .clk         (clk),
    .rst         (rst),
    .chr_vld     (chr_vld),
    .drop        (drop),
    .rd_pop      (rd_pop),
    .st_rd       (st_rd),
    .rd_data     (rd_data),
    .st_ready    (st_ready),
    .st_overrun  (st_overrun),
    .st_brk      (st_brk),
    .st_frm      (st_frm),
    .st_par      (st_par),
    .st_fifo_err (st_fifo_err)
);

// File: tb/test_urx_top.sv
`timescale 1ns/1ps
module test_urx_top;

    localparam int TDIV   = 3;
    localparam int OVS    = 16;
    localparam int BITCLK = TDIV * OVS;
    localparam int DEPTH  = 64;
    localparam int WD     = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_sel = 2'd0;
    logic       pop_req = 1'b0;
    logic       st_rd = 1'b0;
    logic       auto_pop = 1'b0;
    logic       auto_pop_q = 1'b0;
    logic       rd_pop;
    logic [7:0] rd_data;
    logic       st_ready, st_overrun, st_brk, st_frm, st_par, st_fifo_err;

    int  total = 0;
    int  bad   = 0;
    bit  run_cmp = 1'b0;

    assign rd_pop = pop_req | auto_pop_q;

    always #2.5 clk = ~clk;

    urx_top i_urx_top (
        .clk         (clk),
        .rst         (rst),
        .baud_tick   (baud_tick),
        .rx_in       (rx_in),
        .cfg_wlen    (cfg_wlen),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_sel (cfg_par_sel),
        .rd_pop      (rd_pop),
        .st_rd       (st_rd),
        .rd_data     (rd_data),
        .st_ready    (st_ready),
        .st_overrun  (st_overrun),
        .st_brk      (st_brk),
        .st_frm      (st_frm),
        .st_par      (st_par),
        .st_fifo_err (st_fifo_err)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // tick generator
    int tcnt = 0;
    always @(negedge clk) begin
        tcnt = (tcnt == TDIV - 1) ? 0 : tcnt + 1;
        baud_tick = (tcnt == 0);
    end

    // behavioural reference model
    logic [10:0] mq[$];
    int          ms = 0;
    int          mk = 0;
    logic [7:0]  msh;
    logic        mnz, mpb;
    bit          mpend = 1'b0;
    logic [10:0] mpe;
    bit          mov = 1'b0;

    function automatic void model_tick();
        int   n;
        int   j;
        int   ones;
        logic brk, perr;
        n = 5 + int'(cfg_wlen);
        case (ms)
            0: if (!rx_in) begin ms = 1; mk = 0; end
            1: begin
                mk++;
                if (mk == OVS / 2) begin
                    if (rx_in) ms = 0;
                    else begin mnz = 1'b1; msh = 8'h00; end
                end else if (mk > OVS / 2 && (mk - OVS / 2) % OVS == 0) begin
                    j = (mk - OVS / 2) / OVS;
                    if (j <= n) begin
                        msh[j-1] = rx_in;
                        mnz = mnz & !rx_in;
                    end else if (cfg_par_en && j == n + 1) begin
                        mpb = rx_in;
                        mnz = mnz & !rx_in;
                    end else begin
                        brk  = mnz && !rx_in;
                        ones = $countones(msh) + int'(mpb);
                        case (cfg_par_sel)
                            2'd0:    perr = (ones % 2 == 0);
                            2'd1:    perr = (ones % 2 == 1);
                            2'd2:    perr = !mpb;
                            default: perr = mpb;
                        endcase
                        perr  = perr && cfg_par_en && !brk;
                        mpe   = {brk, !rx_in, perr, brk ? 8'h00 : msh};
                        mpend = 1'b1;
                        ms    = brk ? 2 : 0;
                    end
                end
            end
            default: if (rx_in) ms = 0;
        endcase
    endfunction

    always @(posedge clk) begin : mdl
        bit popv, room, oset;
        if (rst) begin
            mq.delete();
            ms = 0; mk = 0; mpend = 1'b0; mov = 1'b0; mpb = 1'b0;
        end else begin
            popv = rd_pop && (mq.size() > 0);
            room = (mq.size() < DEPTH) || popv;
            oset = mpend && !room;
            if (popv) void'(mq.pop_front());
            if (mpend && room) mq.push_back(mpe);
            mov   = (mov && !st_rd) || oset;
            mpend = 1'b0;
            if (baud_tick) model_tick();
        end
    end

    // auto pop raised in the predicted write cycle
    always @(negedge clk) auto_pop_q = auto_pop && mpend;

    // per-cycle comparison against the model
    always @(negedge clk) begin : cmp
        logic [10:0] h;
        bit          anyt;
        if (!rst && run_cmp) begin
            h    = (mq.size() > 0) ? mq[0] : 11'd0;
            anyt = 1'b0;
            foreach (mq[i]) if (|mq[i][10:8]) anyt = 1'b1;
            chk(st_ready == (mq.size() > 0), "R1 ready vs model", st_ready, mq.size() > 0);
            chk(rd_data == h[7:0], "R2 head data vs model", rd_data, h[7:0]);
            chk({st_brk, st_frm, st_par} == h[10:8], "R6 head tags vs model",
                {st_brk, st_frm, st_par}, h[10:8]);
            chk(st_fifo_err == anyt, "R7 summary vs model", st_fifo_err, anyt);
            chk(st_overrun == mov, "R8 overrun vs model", st_overrun, mov);
        end
    end

    task automatic wait_bits(input int nb);
        repeat (nb * BITCLK) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input bit flip_par, input bit low_stop);
        int         n;
        logic [7:0] m;
        logic       pb;
        n = 5 + int'(cfg_wlen);
        m = d & (8'hFF >> (8 - n));
        case (cfg_par_sel)
            2'd0:    pb = ~^m;
            2'd1:    pb = ^m;
            2'd2:    pb = 1'b1;
            default: pb = 1'b0;
        endcase
        rx_in = 1'b0; wait_bits(1);
        for (int i = 0; i < n; i++) begin
            rx_in = m[i]; wait_bits(1);
        end
        if (cfg_par_en) begin
            rx_in = pb ^ flip_par; wait_bits(1);
        end
        rx_in = !low_stop; wait_bits(1);
        rx_in = 1'b1; wait_bits(1);
    endtask

    task automatic pop1();
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin : wdog
        repeat (WD) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run not finished actual=%0d expected<%0d cycles", WD, WD);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(!st_ready && !st_overrun && !st_fifo_err, "R1 reset status", {st_ready, st_overrun, st_fifo_err}, 0);
        chk(!st_brk && !st_frm && !st_par && rd_data == 0, "R1 reset head", rd_data, 0);
        rst = 1'b0;
        run_cmp = 1'b1;
        repeat (7) @(negedge clk);

        // R2: 8-bit characters, arrival order
        send_char(8'hA5, 0, 0);
        chk(st_ready == 1'b1, "R1 ready after frame", st_ready, 1);
        chk(rd_data == 8'hA5, "R2 first character", rd_data, 8'hA5);
        send_char(8'h3C, 0, 0);
        chk(rd_data == 8'hA5, "R2 order head kept", rd_data, 8'hA5);
        pop1();
        chk(rd_data == 8'h3C, "R2 order second", rd_data, 8'h3C);
        pop1();
        chk(st_ready == 1'b0, "R1 empty after pops", st_ready, 0);

        // R2: short words, upper bits zero
        cfg_wlen = 2'd0; send_char(8'hFF, 0, 0);
        chk(rd_data == 8'h1F, "R2 5-bit word", rd_data, 8'h1F); pop1();
        cfg_wlen = 2'd1; send_char(8'hAA, 0, 0);
        chk(rd_data == 8'h2A, "R2 6-bit word", rd_data, 8'h2A); pop1();
        cfg_wlen = 2'd2; send_char(8'hD5, 0, 0);
        chk(rd_data == 8'h55, "R2 7-bit word", rd_data, 8'h55); pop1();

        // R3: each parity kind, matching and mismatching
        cfg_wlen = 2'd3; cfg_par_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            cfg_par_sel = 2'(k);
            send_char(8'h5B, 0, 0);
            chk(st_par == 1'b0 && rd_data == 8'h5B, "R3 parity match", {st_par, rd_data}, 9'h05B);
            pop1();
            send_char(8'h5B, 1, 0);
            chk(st_par == 1'b1 && rd_data == 8'h5B, "R3 parity mismatch", {st_par, rd_data}, 9'h15B);
            pop1();
        end

        // R4: bad stop bit
        cfg_par_en = 1'b0;
        send_char(8'h81, 0, 1);
        chk(st_frm && !st_par && !st_brk, "R4 framing tag", {st_brk, st_frm, st_par}, 3'b010);
        chk(rd_data == 8'h81, "R4 framing data", rd_data, 8'h81);
        pop1();

        // R6/R7: read status then data, tags follow the head
        cfg_par_en = 1'b1; cfg_par_sel = 2'd1;
        send_char(8'h11, 0, 0);
        send_char(8'h22, 1, 0);
        send_char(8'h33, 0, 0);
        chk(!st_par && st_fifo_err, "R6 head clean, R7 summary set", {st_par, st_fifo_err}, 2'b01);
        pop1();
        chk(st_par && rd_data == 8'h22, "R6 tagged head", {st_par, rd_data}, 9'h122);
        chk(st_fifo_err, "R7 summary held", st_fifo_err, 1);
        pop1();
        chk(!st_par && !st_fifo_err && rd_data == 8'h33, "R7 summary cleared", {st_fifo_err, rd_data}, 9'h033);
        pop1();

        // R5: break, single entry, then recovery
        cfg_par_en = 1'b0;
        rx_in = 1'b0; wait_bits(12);
        rx_in = 1'b1; wait_bits(2);
        chk(st_brk && st_frm && rd_data == 8'h00, "R5 break entry", {st_brk, st_frm, rd_data}, 10'h300);
        pop1();
        chk(!st_ready, "R5 one entry per break", st_ready, 0);
        send_char(8'h3C, 0, 0);
        chk(rd_data == 8'h3C && !st_brk, "R5 recovery after break", rd_data, 8'h3C);
        pop1();

        // R9: start glitch
        rx_in = 1'b0; repeat (12) @(negedge clk);
        rx_in = 1'b1; wait_bits(2);
        chk(!st_ready, "R9 glitch ignored", st_ready, 0);
        send_char(8'h96, 0, 0);
        chk(rd_data == 8'h96, "R9 receive after glitch", rd_data, 8'h96);
        pop1();

        // R10: pop on empty
        pop1();
        chk(!st_ready && !st_fifo_err && rd_data == 0, "R10 empty pop", {st_ready, rd_data}, 0);

        // R7: push and pop in the same cycle
        cfg_par_en = 1'b1; cfg_par_sel = 2'd0;
        send_char(8'h44, 1, 0);
        auto_pop = 1'b1;
        send_char(8'h55, 1, 0);
        chk(st_par && st_fifo_err && rd_data == 8'h55, "R7 tagged in, tagged out", {st_fifo_err, rd_data}, 9'h155);
        send_char(8'h66, 0, 0);
        chk(!st_fifo_err && rd_data == 8'h66, "R7 clean in, tagged out", {st_fifo_err, rd_data}, 9'h066);
        send_char(8'h77, 1, 0);
        chk(st_fifo_err && rd_data == 8'h77, "R7 tagged in, clean out", {st_fifo_err, rd_data}, 9'h177);
        auto_pop = 1'b0;
        pop1();
        chk(!st_fifo_err && !st_ready, "R7 cleared after drain", st_fifo_err, 0);

        // R8: full FIFO, overrun and same-cycle pop
        cfg_par_en = 1'b0;
        for (int i = 0; i < DEPTH; i++) send_char(8'(i + 1), 0, 0);
        chk(st_ready && !st_overrun && rd_data == 8'h01, "R8 filled to depth", {st_overrun, rd_data}, 9'h001);
        auto_pop = 1'b1;
        send_char(8'hC8, 0, 0);
        auto_pop = 1'b0;
        chk(!st_overrun && rd_data == 8'h02, "R8 full with pop stores", {st_overrun, rd_data}, 9'h002);
        send_char(8'hC9, 0, 0);
        chk(st_overrun && rd_data == 8'h02, "R8 overrun set", {st_overrun, rd_data}, 9'h102);
        st_rd = 1'b1; @(negedge clk); st_rd = 1'b0; @(negedge clk);
        chk(!st_overrun, "R8 status read clears", st_overrun, 0);
        for (int i = 0; i < DEPTH - 1; i++) pop1();
        chk(rd_data == 8'hC8, "R8 discarded frame absent", rd_data, 8'hC8);
        pop1();
        chk(!st_ready, "R8 drained", st_ready, 0);

        run_cmp = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule